// File: doc/BRIEF.md
# Sync Blanking, Clamp and Frame Event Generator

This block turns raw horizontal and vertical sync inputs into the conditioned timing outputs that a display front end needs. A horizontal blanking output follows either the separated HSYNC or a composite-derived horizontal pulse. A vertical blanking output follows either VSYNC or a composite-derived VSYNC. Each has its own software polarity control. The vertical blanking output is held at its inactive level while an external rate detector reports that the frame rate is too high (above 250 Hz).

A coast output tells a downstream sampling PLL when to stop tracking. It is active for the whole time the selected vertical source is high, and its polarity is programmable. A clamp pulse begins a programmed number of clock ticks after each HSYNC trailing edge and lasts a programmed number of ticks. It has its own enable and polarity. A sticky frame flag is set on every VSYNC leading edge and is cleared only when software writes a zero to it.

All inputs are taken as synchronous to `clk`, and all outputs are registered.

Top module: `sync_cond_gen`

## Requirements
- R1: While `rst_n` is low, at every clock edge all five outputs are driven to 0, and the clamp timer returns to idle.
- R2: One clock after any edge, `hblank_o` equals the source sampled at that edge, XOR `hblank_inv`. The source is `comp_hpulse_i` when `hblank_sel`=1 and `hsync_i` when `hblank_sel`=0.
- R3: One clock after an edge where `vfast_i`=0, `vblank_o` equals the sampled vertical source XOR `vblank_inv`. The source is `comp_vsync_i` when `vblank_sel`=1 and `vsync_i` otherwise.
- R4: One clock after an edge where `vfast_i`=1, `vblank_o` equals the sampled `vblank_inv` (the inactive level), whatever the source.
- R5: One clock after each edge, `coast_o` equals the selected vertical source (as in R3) XOR `coast_inv`. `vfast_i` has no effect on it.
- R6: Let E be an edge at which `hsync_i` is sampled 0 after being sampled 1 at the edge before. With `clamp_en`=1, `clamp_o` is active after edges E+D+1 through E+D+W, where D=`clamp_dly` and W=`clamp_wid`. It is inactive otherwise. The active level is 1 when `clamp_inv`=0 and 0 when `clamp_inv`=1; the inactive level is `clamp_inv`.
- R7: A width of 0 produces no clamp pulse. While `clamp_en`=0, `clamp_o` is held at the inactive level one clock later.
- R8: A new HSYNC trailing edge that arrives before a window has ended restarts the timing from that edge.
- R9: `vflag_o` becomes 1 after any edge at which `vsync_i` is sampled 1 after being sampled 0 at the edge before. After reset, the previous sample counts as 0.
- R10: An edge with `vflag_wr`=1 and `vflag_wdata`=0 clears `vflag_o`. An edge with `vflag_wr`=1 and `vflag_wdata`=1 leaves it unchanged.
- R11: When a VSYNC leading edge and a clearing write fall on the same edge, `vflag_o` is 1 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| hsync_i | input | 1 | Separated horizontal sync, high active |
| vsync_i | input | 1 | Separated vertical sync, high active |
| comp_hpulse_i | input | 1 | Horizontal pulse from composite sync |
| comp_vsync_i | input | 1 | Vertical sync from composite sync |
| vfast_i | input | 1 | Frame rate above 250 Hz |
| hblank_sel | input | 1 | 1: composite horizontal pulse, 0: HSYNC |
| hblank_inv | input | 1 | Invert horizontal blanking output |
| vblank_sel | input | 1 | 1: composite VSYNC, 0: VSYNC |
| vblank_inv | input | 1 | Invert vertical blanking output |
| coast_inv | input | 1 | Invert coast output |
| clamp_en | input | 1 | Clamp pulse enable |
| clamp_inv | input | 1 | Invert clamp output |
| clamp_dly | input | DLY_W | Ticks from HSYNC trailing edge to clamp start |
| clamp_wid | input | WID_W | Clamp width in ticks |
| vflag_wr | input | 1 | Write strobe for the frame flag |
| vflag_wdata | input | 1 | Write data for the frame flag (0 clears) |
| hblank_o | output | 1 | Horizontal blanking |
| vblank_o | output | 1 | Vertical blanking |
| coast_o | output | 1 | PLL coast |
| clamp_o | output | 1 | Clamp pulse |
| vflag_o | output | 1 | Sticky VSYNC leading-edge flag |

## Verification
The bench builds the block with `DLY_W`=4 and `WID_W`=4, so the timer is 5 bits wide. With these widths the largest programmable window, delay 15 plus width 15, can be reached within one short line. That lets the bench cover the far end of the window, the saturated idle count, zero width and restarts on closely spaced HSYNC edges in a few thousand cycles. The HSYNC period is made shorter than the window in one phase, and VSYNC edges are lined up with clearing writes in another.

// File: rtl/sync_cond_gen.sv
module sync_cond_gen #(
  parameter int DLY_W = 8,
  parameter int WID_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hsync_i,
  input  logic             vsync_i,
  input  logic             comp_hpulse_i,
  input  logic             comp_vsync_i,
  input  logic             vfast_i,
  input  logic             hblank_sel,
  input  logic             hblank_inv,
  input  logic             vblank_sel,
  input  logic             vblank_inv,
  input  logic             coast_inv,
  input  logic             clamp_en,
  input  logic             clamp_inv,
  input  logic [DLY_W-1:0] clamp_dly,
  input  logic [WID_W-1:0] clamp_wid,
  input  logic             vflag_wr,
  input  logic             vflag_wdata,
  output logic             hblank_o,
  output logic             vblank_o,
  output logic             coast_o,
  output logic             clamp_o,
  output logic             vflag_o
);

  localparam int CNT_W = ((DLY_W > WID_W) ? DLY_W : WID_W) + 1;
  localparam logic [CNT_W-1:0] IDLE = '1;

  logic             hs_prev, vs_prev;
  logic [CNT_W-1:0] tick;
  logic [CNT_W-1:0] win_lo, win_hi;
  logic             hs_fall, vs_rise, in_win, vsrc, clr_req;

  assign hs_fall = hs_prev & ~hsync_i;
  assign vs_rise = ~vs_prev & vsync_i;
  assign vsrc    = vblank_sel ? comp_vsync_i : vsync_i;
  assign win_lo  = CNT_W'(clamp_dly);
  assign win_hi  = CNT_W'(clamp_dly) + CNT_W'(clamp_wid);
  assign in_win  = (tick >= win_lo) && (tick < win_hi);
  assign clr_req = vflag_wr & ~vflag_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hs_prev <= 1'b0;
      vs_prev <= 1'b0;
      tick    <= IDLE;
    end else begin
      hs_prev <= hsync_i;
      vs_prev <= vsync_i;
      if (hs_fall)
        tick <= '0;
      else if (tick != IDLE)
        tick <= tick + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hblank_o <= 1'b0;
      vblank_o <= 1'b0;
      coast_o  <= 1'b0;
      clamp_o  <= 1'b0;
      vflag_o  <= 1'b0;
    end else begin
      hblank_o <= (hblank_sel ? comp_hpulse_i : hsync_i) ^ hblank_inv;
      vblank_o <= vfast_i ? vblank_inv : (vsrc ^ vblank_inv);
      coast_o  <= vsrc ^ coast_inv;
      clamp_o  <= (clamp_en & in_win) ^ clamp_inv;
      if (vs_rise)
        vflag_o <= 1'b1;
      else if (clr_req)
        vflag_o <= 1'b0;
    end
  end

endmodule

// File: rtl/sync_cond_gen_chk.sv
module sync_cond_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic hsync_i,
  input logic vsync_i,
  input logic comp_hpulse_i,
  input logic comp_vsync_i,
  input logic vfast_i,
  input logic hblank_sel,
  input logic hblank_inv,
  input logic vblank_sel,
  input logic vblank_inv,
  input logic coast_inv,
  input logic clamp_en,
  input logic clamp_inv,
  input logic vflag_wr,
  input logic vflag_wdata,
  input logic hblank_o,
  input logic vblank_o,
  input logic coast_o,
  input logic clamp_o,
  input logic vflag_o
);

  a_r2_hblank_follows: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> hblank_o == ($past(hblank_sel ? comp_hpulse_i : hsync_i) ^ $past(hblank_inv)));

  a_r4_vblank_cut: assert property (@(posedge clk) disable iff (!rst_n)
    vfast_i |=> vblank_o == $past(vblank_inv));

  a_r5_coast_ignores_fast: assert property (@(posedge clk) disable iff (!rst_n)
    (vfast_i && !vblank_sel) |=> coast_o == ($past(vsync_i) ^ $past(coast_inv)));

  a_r7_clamp_held_off: assert property (@(posedge clk) disable iff (!rst_n)
    !clamp_en |=> clamp_o == $past(clamp_inv));

  a_r9_vflag_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && vsync_i && !$past(vsync_i)) |=> vflag_o);

  a_r10_vflag_keep_on_one: assert property (@(posedge clk) disable iff (!rst_n)
    (vflag_o && vflag_wr && vflag_wdata) |=> vflag_o);

  a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && vsync_i && !$past(vsync_i) && vflag_wr && !vflag_wdata) |=> vflag_o);

endmodule

bind sync_cond_gen sync_cond_gen_chk u_chk (.*);

// File: tb/sync_cond_gen_test.sv
module sync_cond_gen_test;
  localparam int DW = 4;
  localparam int WW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hsync_i = 0, vsync_i = 0, comp_hpulse_i = 0, comp_vsync_i = 0, vfast_i = 0;
  logic hblank_sel = 0, hblank_inv = 0, vblank_sel = 0, vblank_inv = 0, coast_inv = 0;
  logic clamp_en = 0, clamp_inv = 0, vflag_wr = 0, vflag_wdata = 0;
  logic [DW-1:0] clamp_dly = '0;
  logic [WW-1:0] clamp_wid = '0;
  logic hblank_o, vblank_o, coast_o, clamp_o, vflag_o;

  always #4 clk = ~clk;

  sync_cond_gen #(.DLY_W(DW), .WID_W(WW)) uut (.*);

  int vectors = 0, miscompares = 0;
  bit done = 0;

  // behavioural reference
  logic e_hb = 0, e_vb = 0, e_co = 0, e_cl = 0, e_vf = 0;
  int   ticks = -1;
  logic m_hp = 0, m_vp = 0;

  always @(posedge clk) begin
    logic src;
    if (!rst_n) begin
      {e_hb, e_vb, e_co, e_cl, e_vf} = '0;
      ticks = -1; m_hp = 0; m_vp = 0;
    end else begin
      e_hb = (hblank_sel ? comp_hpulse_i : hsync_i) ^ hblank_inv;
      src  = vblank_sel ? comp_vsync_i : vsync_i;
      e_vb = vfast_i ? vblank_inv : (src ^ vblank_inv);
      e_co = src ^ coast_inv;
      e_cl = (clamp_en && ticks >= int'(clamp_dly) &&
              ticks < int'(clamp_dly) + int'(clamp_wid)) ^ clamp_inv;
      if (!m_vp && vsync_i) e_vf = 1;
      else if (vflag_wr && !vflag_wdata) e_vf = 0;
      if (m_hp && !hsync_i) ticks = 0;
      else if (ticks >= 0) ticks++;
      m_hp = hsync_i; m_vp = vsync_i;
    end
  end

  task automatic cmp(string tag, logic act, logic exp);
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
    end
  endtask

  task automatic check_all();
    vectors++;
    cmp("R2 hblank", hblank_o, e_hb);
    cmp("R3/R4 vblank", vblank_o, e_vb);
    cmp("R5 coast", coast_o, e_co);
    cmp("R6/R7/R8 clamp", clamp_o, e_cl);
    cmp("R9/R10/R11 vflag", vflag_o, e_vf);
  endtask

  int hh = 6, hl = 30, hc = 0;
  int vprob = 20, wprob = 10, fprob = 0;

  task automatic step();
    @(negedge clk);
    check_all();
    hsync_i = (hc < hh);
    hc = (hc + 1) % (hh + hl);
    if ($urandom_range(99) < vprob) vsync_i = ~vsync_i;
    comp_hpulse_i = $urandom_range(1);
    comp_vsync_i  = $urandom_range(1);
    vfast_i       = ($urandom_range(99) < fprob);
    vflag_wr      = ($urandom_range(99) < wprob);
    vflag_wdata   = $urandom_range(1);
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic ctl(logic hs, logic hi, logic vs, logic vi, logic ci,
                     logic en, logic li, int d, int w);
    hblank_sel = hs; hblank_inv = hi; vblank_sel = vs; vblank_inv = vi;
    coast_inv = ci; clamp_en = en; clamp_inv = li;
    clamp_dly = DW'(d); clamp_wid = WW'(w);
  endtask

  initial begin
    void'($urandom(7));
    hsync_i = 1; vsync_i = 1;
    repeat (3) begin
      @(negedge clk);
      vectors++;
      // R1: outputs held at 0 during reset
      cmp("R1 reset", {hblank_o, vblank_o, coast_o, clamp_o, vflag_o} == 5'b0, 1'b1);
    end
    rst_n = 1;
    // R2 R3 R5 R6: plain polarity, mid window
    ctl(0, 0, 0, 0, 0, 1, 0, 3, 5);  run(300);
    // inverted everything, composite sources
    ctl(1, 1, 1, 1, 1, 1, 1, 0, 1);  run(300);
    // R4: frame rate too high, coast unaffected
    fprob = 50;
    ctl(0, 1, 0, 0, 1, 1, 0, 15, 15); run(400);
    ctl(1, 0, 1, 1, 0, 1, 1, 7, 2);   run(300);
    fprob = 0;
    // R7: width zero, then disabled
    ctl(0, 0, 0, 0, 0, 1, 0, 4, 0);  run(200);
    ctl(0, 0, 0, 0, 0, 0, 1, 2, 6);  run(200);
    // R8: lines shorter than the window
    hh = 3; hl = 5; hc = 0;
    ctl(0, 0, 0, 0, 0, 1, 0, 6, 12); run(300);
    hh = 2; hl = 3;
    ctl(0, 0, 0, 0, 0, 1, 1, 15, 15); run(300);
    hh = 6; hl = 30;
    // R10 R11: frequent writes and VSYNC edges
    vprob = 50; wprob = 60;
    ctl(0, 0, 0, 0, 0, 1, 0, 1, 1);  run(1500);
    // R11 directed: rising edge together with a clearing write
    vprob = 0; wprob = 0;
    @(negedge clk); check_all(); vsync_i = 0; vflag_wr = 0;
    @(negedge clk); check_all(); vsync_i = 1; vflag_wr = 1; vflag_wdata = 0;
    @(negedge clk); check_all(); vflag_wr = 0;
    @(negedge clk); check_all();
    cmp("R11 set beats clear", vflag_o, 1'b1);
    // R10 directed: write 1 keeps, write 0 clears
    vflag_wr = 1; vflag_wdata = 1;
    @(negedge clk); check_all(); vflag_wr = 0;
    @(negedge clk); check_all();
    cmp("R10 write one no effect", vflag_o, 1'b1);
    vflag_wr = 1; vflag_wdata = 0;
    @(negedge clk); check_all(); vflag_wr = 0;
    @(negedge clk); check_all();
    cmp("R10 write zero clears", vflag_o, 1'b0);
    // R1: reset mid-run
    rst_n = 0;
    @(negedge clk); @(negedge clk);
    vectors++;
    cmp("R1 reset mid-run", {hblank_o, vblank_o, coast_o, clamp_o, vflag_o} == 5'b0, 1'b1);
    rst_n = 1;
    run(200);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule